// File: doc/BRIEF.md
# Optical Label Swap Processor

This block sits behind the payload splitter of one input of a packet switch. It receives the header of each packet as a serial bit stream, one bit per clock, with a strobe marking the first bit. Once all sixteen bits are held in parallel, the block decides where the packet goes. It checks the marker bit and the hop count, and it looks the destination address up in a small forwarding table. It then asks a scheduler for the chosen output port, passing along the packet's class bits.

For a forwarded packet the outgoing header keeps the class bits and has its hop count lowered by one. Its address is replaced with the value stored in the matching table entry. A header that is malformed, has run out of hops or hits no table entry is sent to a dedicated discard port, and its header goes out unchanged. In a diagnostic mode the outgoing header is always a bit-exact copy of what was captured. The new header leaves serially after a programmable gap counted from the end of capture, which keeps it aligned with the payload held in the external delay line.

At a 4 ns clock, the request reaches the scheduler 17 cycles (68 ns) after the first header bit. That is inside a 90 ns decision budget.

Top module: `label_swap_top`

## Requirements
- R1: The header is captured most significant bit first. The bit present in the cycle `lbl_start` is high is bit 15, and the next fifteen cycles carry bits 14 down to 0. Bit fields are: [15] marker, [14:13] class, [12:10] hop count, [9:0] address.
- R2: For a forwarded header, the outgoing header has marker 1, the class field copied unchanged, the hop count minus one, and the address replaced by the matching entry's replacement address. A hop count of 1 leaves as 0.
- R3: A table entry is written in the cycle `tbl_wr_en` is high. An entry matches when its valid bit is 1 and its key equals the captured address. When several entries match, the lowest index wins. An entry written with valid 0 never matches.
- R4: A header whose marker bit is 0 is sent to port 4 (the discard port), and its outgoing header equals the captured header.
- R5: A header whose hop count is 0 is sent to port 4, and its outgoing header equals the captured header.
- R6: A header whose address matches no valid entry is sent to port 4, and its outgoing header equals the captured header.
- R7: While `test_mode` is 1, the outgoing header equals the captured header bit for bit. Port selection is unchanged from normal operation.
- R8: `sched_req` rises 17 cycles after the cycle carrying bit 15, together with the port (0 to 3 for a hit, 4 for discard) and the class bits. The request and its fields hold steady until `sched_gnt` is sampled high, and the request is low in the cycle after that.
- R9: The first outgoing bit appears `launch_gap` cycles after the cycle in which `sched_req` rises; a gap of 0 means that same cycle. The sixteen bits follow in consecutive cycles, most significant first, with `out_valid` high throughout and `out_start` high only on the first. `out_bit` is 0 while `out_valid` is low.
- R10: After reset, `sched_req`, `out_valid` and `out_start` are low and every table entry is invalid.
- R11: A `lbl_start` pulse arriving in the middle of a capture abandons the partial header and starts a new capture. Only the new header produces a request and an outgoing header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lbl_start | input | 1 | High with the first header bit |
| lbl_bit | input | 1 | Serial header bit |
| tbl_wr_en | input | 1 | Forwarding-table write strobe |
| tbl_wr_idx | input | 3 | Entry index to write |
| tbl_wr_vld | input | 1 | Valid bit of the written entry |
| tbl_wr_key | input | 10 | Address the entry matches |
| tbl_wr_addr | input | 10 | Replacement address |
| tbl_wr_port | input | 2 | Output port of the entry |
| test_mode | input | 1 | Copy the captured header unchanged |
| launch_gap | input | 8 | Cycles from request to first outgoing bit |
| sched_req | output | 1 | Request toward the scheduler |
| sched_port | output | 3 | Requested port, 4 = discard |
| sched_qos | output | 2 | Class bits of the packet |
| sched_gnt | input | 1 | Grant from the scheduler |
| out_bit | output | 1 | Serial outgoing header bit |
| out_valid | output | 1 | Outgoing bit is valid |
| out_start | output | 1 | First outgoing bit |

## Verification
The bench sends a hop count of 1 and checks that it leaves as 0. A design that checked the hop count after decrementing it would discard such a packet, or would let a count of 0 wrap to 7. Two entries are given the same key, and one entry is cleared by writing it with valid 0. A design with the wrong priority, or one that ignored the valid bit, would report the wrong port and replacement address. A header is cut short by a fresh start strobe, and a design that kept counting the old header would emit a scrambled header or two requests. The launch gap is tested at 0 and at 20, which exposes any off-by-one in the delay counter as a first bit in the wrong cycle. The request is also held ungranted for a cycle, which catches a design that drops it or lets its port change.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int LBL_W     = 16;
    localparam int QOS_W     = 2;
    localparam int HOP_W     = 3;
    localparam int ADDR_W    = 10;
    localparam int NUM_OUT   = 4;
    localparam int OUT_IDX_W = $clog2(NUM_OUT);
    localparam int PORT_W    = $clog2(NUM_OUT + 1);
    localparam logic [PORT_W-1:0] DISCARD_PORT = PORT_W'(NUM_OUT);

    // field order follows transmission order, marker first
    typedef struct packed {
        logic              mark;
        logic [QOS_W-1:0]  qos;
        logic [HOP_W-1:0]  hops;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic                 vld;
        logic [ADDR_W-1:0]    key;
        logic [ADDR_W-1:0]    repl;
        logic [OUT_IDX_W-1:0] port;
    } fwd_entry_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] repl;
        logic [OUT_IDX_W-1:0] port;
    } lookup_t;

    function automatic logic hdr_bad(hdr_t h, logic hit);
        return (!h.mark) || (h.hops == '0) || (!hit);
    endfunction

    function automatic hdr_t hdr_rewrite(hdr_t h, logic [ADDR_W-1:0] repl);
        hdr_t r;
        r      = h;
        r.hops = HOP_W'(h.hops - HOP_W'(1));
        r.addr = repl;
        return r;
    endfunction

endpackage

// File: rtl/lsp_deser.sv
module lsp_deser
    import lsp_pkg::*;
#(
    parameter int NBITS = LBL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             din,
    output logic [NBITS-1:0] word,
    output logic             done
);
    localparam int CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

    logic [CNT_W-1:0] cnt;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                word <= {{(NBITS-1){1'b0}}, din};
                cnt  <= CNT_W'(1);
                busy <= 1'b1;
            end else if (busy) begin
                word <= {word[NBITS-2:0], din};
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    restart_nodone_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

endmodule

// File: rtl/lsp_fwd_table.sv
module lsp_fwd_table
    import lsp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx,
    input  fwd_entry_t                wr_entry,
    input  logic [ADDR_W-1:0]         key,
    output lookup_t                   result
);
    localparam int IDX_W = $clog2(DEPTH);

    fwd_entry_t       ent [DEPTH];
    logic [DEPTH-1:0] match;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[g] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    ent[g] <= wr_entry;
                end
            end
            assign match[g] = ent[g].vld && (ent[g].key == key);
        end
    endgenerate

    // lowest index has priority: scan downward so it is assigned last
    always_comb begin
        result = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                result.hit  = 1'b1;
                result.repl = ent[i].repl;
                result.port = ent[i].port;
            end
        end
    end

    // R3
    write_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_entry.vld) && key == $past(wr_entry.key)) |-> result.hit);

endmodule

// File: rtl/lsp_serializer.sv
module lsp_serializer
    import lsp_pkg::*;
#(
    parameter int NBITS = LBL_W,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NBITS-1:0] word,
    input  logic [GAP_W-1:0] gap,
    output logic             out_bit,
    output logic             out_valid,
    output logic             out_start
);
    localparam int CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} ser_state_t;

    ser_state_t       state;
    logic [NBITS-1:0] sreg;
    logic [GAP_W-1:0] wait_cnt;
    logic [CNT_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            sreg     <= '0;
            wait_cnt <= '0;
            idx      <= '0;
        end else if (load) begin
            sreg     <= word;
            idx      <= '0;
            wait_cnt <= gap - GAP_W'(1);
            state    <= (gap == '0) ? S_SHIFT : S_WAIT;
        end else begin
            unique case (state)
                S_WAIT: begin
                    if (wait_cnt == '0) state <= S_SHIFT;
                    else                wait_cnt <= wait_cnt - GAP_W'(1);
                end
                S_SHIFT: begin
                    sreg <= {sreg[NBITS-2:0], 1'b0};
                    idx  <= idx + CNT_W'(1);
                    if (idx == LAST) state <= S_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign out_valid = (state == S_SHIFT);
    assign out_start = out_valid && (idx == '0);
    assign out_bit   = out_valid && sreg[NBITS-1];

    // R9
    first_bit_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_start);

    // R9
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_bit && !out_start);

endmodule

// File: rtl/label_swap_top.sv
module label_swap_top
    import lsp_pkg::*;
#(
    parameter int TBL_DEPTH = 8,
    parameter int GAP_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lbl_start,
    input  logic                         lbl_bit,
    input  logic                         tbl_wr_en,
    input  logic [$clog2(TBL_DEPTH)-1:0] tbl_wr_idx,
    input  logic                         tbl_wr_vld,
    input  logic [9:0]                   tbl_wr_key,
    input  logic [9:0]                   tbl_wr_addr,
    input  logic [1:0]                   tbl_wr_port,
    input  logic                         test_mode,
    input  logic [GAP_W-1:0]             launch_gap,
    output logic                         sched_req,
    output logic [2:0]                   sched_port,
    output logic [1:0]                   sched_qos,
    input  logic                         sched_gnt,
    output logic                         out_bit,
    output logic                         out_valid,
    output logic                         out_start
);
    logic [LBL_W-1:0] cap_word;
    logic             cap_done;
    hdr_t             cap_hdr;
    lookup_t          look;
    fwd_entry_t       wr_entry;
    logic             bad;
    hdr_t             new_hdr;
    logic [PORT_W-1:0] new_port;

    lsp_deser #(.NBITS(LBL_W)) deser_i (
        .clk  (clk),
        .rst  (rst),
        .start(lbl_start),
        .din  (lbl_bit),
        .word (cap_word),
        .done (cap_done)
    );

    assign cap_hdr  = hdr_t'(cap_word);
    assign wr_entry = '{vld: tbl_wr_vld, key: tbl_wr_key,
                        repl: tbl_wr_addr, port: tbl_wr_port};

    lsp_fwd_table #(.DEPTH(TBL_DEPTH)) table_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_entry(wr_entry),
        .key     (cap_hdr.addr),
        .result  (look)
    );

    always_comb begin
        bad      = hdr_bad(cap_hdr, look.hit);
        new_port = bad ? DISCARD_PORT : PORT_W'(look.port);
        new_hdr  = (bad || test_mode) ? cap_hdr : hdr_rewrite(cap_hdr, look.repl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sched_req  <= 1'b0;
            sched_port <= '0;
            sched_qos  <= '0;
        end else if (cap_done) begin
            sched_req  <= 1'b1;
            sched_port <= new_port;
            sched_qos  <= cap_hdr.qos;
        end else if (sched_req && sched_gnt) begin
            sched_req  <= 1'b0;
        end
    end

    lsp_serializer #(.NBITS(LBL_W), .GAP_W(GAP_W)) ser_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cap_done),
        .word     (LBL_W'(new_hdr)),
        .gap      (launch_gap),
        .out_bit  (out_bit),
        .out_valid(out_valid),
        .out_start(out_start)
    );

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sched_req && !sched_gnt && !cap_done) |=>
            sched_req && $stable(sched_port) && $stable(sched_qos));

    // R8
    req_release_chk: assert property (@(posedge clk) disable iff (rst)
        (sched_req && sched_gnt && !cap_done) |=> !sched_req);

    // R4
    marker_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_done && !cap_hdr.mark) |=> sched_port == DISCARD_PORT);

    // R5
    hops_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_done && cap_hdr.hops == '0) |=> sched_port == DISCARD_PORT);

endmodule

// File: tb/label_swap_top_tb_top.sv
module label_swap_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lbl_start = 1'b0, lbl_bit = 1'b0;
    logic       tbl_wr_en = 1'b0, tbl_wr_vld = 1'b0;
    logic [2:0] tbl_wr_idx = '0;
    logic [9:0] tbl_wr_key = '0, tbl_wr_addr = '0;
    logic [1:0] tbl_wr_port = '0;
    logic       test_mode = 1'b0;
    logic [7:0] launch_gap = 8'd20;
    logic       sched_req, sched_gnt = 1'b0;
    logic [2:0] sched_port;
    logic [1:0] sched_qos;
    logic       out_bit, out_valid, out_start;

    int checks = 0, fails = 0, cyc = 0;

    typedef struct { logic [15:0] hdr; int cyc; string tag; } exp_t;
    exp_t exp_q[$];

    bit         m_vld [8];
    logic [9:0] m_key [8], m_repl [8];
    logic [1:0] m_port [8];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    label_swap_top dut_i (
        .clk(clk), .rst(rst), .lbl_start(lbl_start), .lbl_bit(lbl_bit),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_vld(tbl_wr_vld),
        .tbl_wr_key(tbl_wr_key), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_port(tbl_wr_port),
        .test_mode(test_mode), .launch_gap(launch_gap),
        .sched_req(sched_req), .sched_port(sched_port), .sched_qos(sched_qos),
        .sched_gnt(sched_gnt), .out_bit(out_bit), .out_valid(out_valid),
        .out_start(out_start)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // reference model written from the requirements
    task automatic model(input logic [15:0] h, input bit tm,
                         output logic [2:0] port, output logic [15:0] oh);
        int  hit_i = -1;
        for (int i = 7; i >= 0; i--)
            if (m_vld[i] && m_key[i] == h[9:0]) hit_i = i;
        if (!h[15] || h[12:10] == 3'd0 || hit_i < 0) begin
            port = 3'd4;
            oh   = h;
        end else begin
            port = {1'b0, m_port[hit_i]};
            oh   = tm ? h : {h[15:13], 3'(h[12:10] - 3'd1), m_repl[hit_i]};
        end
    endtask

    task automatic tbl_write(int idx, bit v, logic [9:0] k, logic [9:0] r, logic [1:0] p);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = 3'(idx); tbl_wr_vld = v;
        tbl_wr_key = k; tbl_wr_addr = r; tbl_wr_port = p;
        m_vld[idx] = v; m_key[idx] = k; m_repl[idx] = r; m_port[idx] = p;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic send(logic [15:0] h, string tag);
        logic [2:0]  ep;
        logic [15:0] eh;
        int          n;
        exp_t        e;
        model(h, test_mode, ep, eh);
        @(negedge clk);
        n = cyc;
        e.hdr = eh; e.cyc = n + 17 + int'(launch_gap); e.tag = tag;
        exp_q.push_back(e);
        lbl_start = 1'b1; lbl_bit = h[15];
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            lbl_start = 1'b0; lbl_bit = h[15-i];
        end
        @(negedge clk);
        lbl_bit = 1'b0;
        @(negedge clk);
        chk(sched_req == 1'b1, {tag, " R8 request raised"}, 32'(sched_req), 1);
        chk(sched_port == ep, {tag, " port"}, 32'(sched_port), 32'(ep));
        chk(sched_qos == h[14:13], {tag, " R8 class bits"}, 32'(sched_qos), 32'(h[14:13]));
        @(negedge clk);
        chk(sched_req && sched_port == ep, {tag, " R8 held ungranted"},
            {28'd0, sched_req, sched_port}, {28'd0, 1'b1, ep});
        sched_gnt = 1'b1;
        @(negedge clk);
        sched_gnt = 1'b0;
        chk(sched_req == 1'b0, {tag, " R8 released"}, 32'(sched_req), 0);
        while (exp_q.size() != 0 || out_valid) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: gathers outgoing headers and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                logic [15:0] got;
                int          st;
                exp_t        e;
                bit          shape_ok;
                got = '0; st = cyc; shape_ok = 1'b1;
                for (int i = 0; i < 16; i++) begin
                    if (!out_valid || out_start != (i == 0)) shape_ok = 1'b0;
                    got = {got[14:0], out_bit};
                    if (i < 15) @(negedge clk);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected header", 32'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e.hdr, {e.tag, " outgoing header"}, 32'(got), 32'(e.hdr));
                    chk(st == e.cyc, {e.tag, " R9 launch cycle"}, 32'(st), 32'(e.cyc));
                    chk(shape_ok, {e.tag, " R9 valid/start shape"}, 32'(shape_ok), 1);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sched_req && !out_valid && !out_start, "R10 reset outputs",
            {29'd0, sched_req, out_valid, out_start}, 0);

        // R10: empty table after reset, a well-formed header still discards
        send({1'b1, 2'd1, 3'd4, 10'h155}, "R10 empty table");

        tbl_write(0, 1'b1, 10'h155, 10'h2AA, 2'd1);
        tbl_write(1, 1'b1, 10'h0F0, 10'h30F, 2'd3);
        tbl_write(2, 1'b1, 10'h155, 10'h001, 2'd2);
        tbl_write(3, 1'b0, 10'h3FF, 10'h123, 2'd0);

        send({1'b1, 2'd2, 3'd5, 10'h155}, "R1 R2 R3 forward lowest index");
        send({1'b1, 2'd1, 3'd7, 10'h0F0}, "R2 forward");
        send({1'b1, 2'd3, 3'd1, 10'h0F0}, "R2 hop count one");
        send({1'b1, 2'd0, 3'd0, 10'h155}, "R5 zero hops");
        send({1'b0, 2'd2, 3'd6, 10'h155}, "R4 marker clear");
        send({1'b1, 2'd1, 3'd3, 10'h3FF}, "R6 R3 invalid entry miss");
        send({1'b1, 2'd1, 3'd3, 10'h2B7}, "R6 absent address");

        test_mode = 1'b1;
        send({1'b1, 2'd3, 3'd2, 10'h0F0}, "R7 copy on hit");
        test_mode = 1'b0;

        launch_gap = 8'd0;
        send({1'b1, 2'd0, 3'd6, 10'h0F0}, "R9 zero gap");
        launch_gap = 8'd20;

        tbl_write(0, 1'b0, 10'h155, 10'h2AA, 2'd1);
        send({1'b1, 2'd2, 3'd4, 10'h155}, "R3 cleared entry falls through");

        // R11: abandoned partial header followed by a full one
        @(negedge clk);
        lbl_start = 1'b1; lbl_bit = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            lbl_start = 1'b0; lbl_bit = 1'(i % 2);
        end
        send({1'b1, 2'd1, 3'd2, 10'h0F0}, "R11 restart");
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0 && !sched_req, "R11 single request",
            32'(exp_q.size()), 0);

        finish_up();
    end

endmodule